// File: doc/BRIEF.md
# Serial IRQ frame controller

This block is the host end of a single shared interrupt line on which the host and any number of peripherals report interrupt requests in time slots. Every agent drives the line only on rising edges of the bus clock, and a pull-up holds it high whenever nobody drives. The host opens each frame with a long low pulse. It then lets a fixed number of three-clock slots pass and closes the frame with a short low pulse. Each peripheral pulls the line low in the first clock of the slot belonging to the interrupt it wants to raise.

Every agent that pulls the line low must drive it high on the next clock and release it on the clock after that. With this rule a pulled-up line always returns high quickly without any agent fighting another. The host samples the line in the first clock of every slot and rebuilds a vector of request levels, which it presents as a whole once the frame closes. Frames follow one another without a gap from the moment reset ends.

The project also provides a peripheral-side slot driver that follows the same rule, and a wired-line resolver that merges any number of drive-enable/drive-value pairs. A testbench uses both to build a complete line.

Top module: `sirq_frame_host`

## Requirements
- R1: In the first clock after reset is released, and at the start of every frame, the host drives the line low for START_LEN clocks (default 4), counted as frame clocks 0 to 3.
- R2: Whenever the host has driven the line low, it drives it high for exactly one clock as soon as it stops driving low, and releases it on the following clock.
- R3: A frame holds NUM_SLOTS (default 17) slots of three clocks each. The sample clock of slot s is frame clock 6+3s, followed by a recovery clock and a turnaround clock. The host leaves the line released in all slot clocks.
- R4: The host drives the line low in frame clocks 57 and 58, high in clock 59, and releases it in clock 60. Each frame lasts 61 clocks, and frame clock 0 of the next frame follows at once.
- R5: Bit s of irq_level reads 1 when the line was low in the sample clock of slot s, and 0 when it was high there. Slot 0 is the first slot after the start pulse.
- R6: irq_level changes only on the clock edge that ends a frame. The values gathered in one frame appear in frame clock 0 of the next frame and hold for that whole frame.
- R7: While reset is asserted, irq_level is all zeros and the host does not drive the line. Reset takes effect without waiting for a clock edge.
- R8: A low level on the line during the recovery or turnaround clock of a slot does not set any bit of irq_level.
- R9: The slot driver drives the line low in the sample clock of slot s when req[s] is 1, high in the clock after it, and releases it in the turnaround clock. When req[s] is 0 it leaves the slot released.
- R10: The slot driver leaves the line released outside the slots. It starts counting slots only after seeing the line low for at least START_LEN consecutive clocks and then high, so the shorter closing pulse does not start it.
- R11: The resolved line is low when any enabled driver drives low. It is high in every other case.
- R12: No two enabled drivers drive opposite values in the same clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; the line changes only on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sirq_in | input | 1 | Resolved level of the shared line |
| sirq_oe | output | 1 | Host drive enable for the line |
| sirq_out | output | 1 | Host drive value, meaningful while sirq_oe is 1 |
| irq_level | output | NUM_SLOTS | Request level per slot, bit s for slot s, 1 = active |

## Verification
The hardest cases to reach are a low level on the line outside a sample clock, and a change of the request pattern while a frame is still running. A well-behaved slot driver never produces the first, and the second only shows up if the output is watched before the frame closes. The bench therefore adds a third driver to the wired line. This driver pulls the line low for single clocks in chosen recovery, turnaround and sample clocks. The bench also swaps the request pattern at frame clock 1 and reads irq_level in the middle of that frame, at its last clock and in the first clock of the next frame.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

   // One agent's contribution to the shared line.
   typedef struct packed {
      logic en;
      logic val;
   } sirq_drive_t;

   localparam sirq_drive_t DRV_OFF  = '{en: 1'b0, val: 1'b1};
   localparam sirq_drive_t DRV_LOW  = '{en: 1'b1, val: 1'b0};
   localparam sirq_drive_t DRV_HIGH = '{en: 1'b1, val: 1'b1};

   // Host frame phases, in the order they occur.
   typedef enum logic [2:0] {
      PH_START,
      PH_START_REC,
      PH_START_TA,
      PH_SLOT,
      PH_STOP,
      PH_STOP_REC,
      PH_STOP_TA
   } frame_phase_e;

   // Peripheral tracking states.
   typedef enum logic [1:0] {
      AG_IDLE,
      AG_LEAD,
      AG_RUN
   } agent_state_e;

   function automatic int unsigned frame_clocks(int unsigned slots,
                                                int unsigned start_len,
                                                int unsigned stop_len);
      return start_len + 2 + 3 * slots + stop_len + 2;
   endfunction

endpackage

// File: rtl/sirq_frame_seq.sv
module sirq_frame_seq
   import sirq_pkg::*;
#(
   parameter int unsigned NUM_SLOTS = 17,
   parameter int unsigned START_LEN = 4,
   parameter int unsigned STOP_LEN  = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   output logic                         drv_en,
   output logic                         drv_val,
   output logic                         sample_stb,
   output logic [$clog2(NUM_SLOTS)-1:0] slot_idx,
   output logic                         frame_end
);

   localparam int unsigned SW    = $clog2(NUM_SLOTS);
   localparam int unsigned CMAX  = (START_LEN > STOP_LEN) ? START_LEN : STOP_LEN;
   localparam int unsigned CMAX3 = (CMAX > 3) ? CMAX : 3;
   localparam int unsigned CW    = $clog2(CMAX3);

   frame_phase_e  phase_q;
   logic [CW-1:0] cnt_q;
   logic [SW-1:0] slot_q;
   logic          cnt_last;
   sirq_drive_t   drv;

   always_comb begin
      case (phase_q)
         PH_START: cnt_last = (cnt_q == CW'(START_LEN - 1));
         PH_STOP:  cnt_last = (cnt_q == CW'(STOP_LEN - 1));
         PH_SLOT:  cnt_last = (cnt_q == CW'(2));
         default:  cnt_last = 1'b1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_START;
         cnt_q   <= '0;
         slot_q  <= '0;
      end else if (!cnt_last) begin
         cnt_q <= cnt_q + 1'b1;
      end else begin
         cnt_q <= '0;
         case (phase_q)
            PH_START:     phase_q <= PH_START_REC;
            PH_START_REC: phase_q <= PH_START_TA;
            PH_START_TA: begin
               phase_q <= PH_SLOT;
               slot_q  <= '0;
            end
            PH_SLOT: begin
               if (slot_q == SW'(NUM_SLOTS - 1)) phase_q <= PH_STOP;
               else                              slot_q  <= slot_q + 1'b1;
            end
            PH_STOP:      phase_q <= PH_STOP_REC;
            PH_STOP_REC:  phase_q <= PH_STOP_TA;
            default:      phase_q <= PH_START;
         endcase
      end
   end

   always_comb begin
      case (phase_q)
         PH_START, PH_STOP:         drv = DRV_LOW;
         PH_START_REC, PH_STOP_REC: drv = DRV_HIGH;
         default:                   drv = DRV_OFF;
      endcase
   end

   assign drv_en     = drv.en & rst_n;
   assign drv_val    = drv.val;
   assign sample_stb = (phase_q == PH_SLOT) && (cnt_q == '0);
   assign slot_idx   = slot_q;
   assign frame_end  = (phase_q == PH_STOP_TA);

   // R2: a low drive is always followed by one clock of high drive
   assert_high_after_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(drv_en && !drv_val) && !(drv_en && !drv_val)) |-> (drv_en && drv_val));

   // R2: a high drive lasts one clock, then the line is released
   assert_release_after_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(drv_en && drv_val) |-> !drv_en);

endmodule

// File: rtl/sirq_slot_capture.sv
module sirq_slot_capture #(
   parameter int unsigned NUM_SLOTS = 17
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         line,
   input  logic                         sample_stb,
   input  logic [$clog2(NUM_SLOTS)-1:0] slot_idx,
   input  logic                         frame_end,
   output logic [NUM_SLOTS-1:0]         irq_level
);

   localparam int unsigned SW = $clog2(NUM_SLOTS);

   logic [NUM_SLOTS-1:0] shadow;

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      logic hit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                   hit_q <= 1'b0;
         else if (sample_stb && slot_idx == SW'(s))    hit_q <= ~line;
      end
      assign shadow[s] = hit_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         irq_level <= '0;
      else if (frame_end) irq_level <= shadow;
   end

   // R6: the request vector moves only on the edge closing a frame
   assert_update_at_frame_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(irq_level) |-> $past(frame_end));

endmodule

// File: rtl/sirq_slot_agent.sv
module sirq_slot_agent
   import sirq_pkg::*;
#(
   parameter int unsigned NUM_SLOTS = 17,
   parameter int unsigned START_LEN = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 line,
   input  logic [NUM_SLOTS-1:0] req,
   output logic                 drv_en,
   output logic                 drv_val
);

   localparam int unsigned SW = $clog2(NUM_SLOTS);
   localparam int unsigned RW = $clog2(START_LEN + 1);

   agent_state_e  state_q;
   logic [RW-1:0] lowrun_q;
   logic [1:0]    sub_q;
   logic [SW-1:0] slot_q;
   logic          low_q;
   logic          start_seen;
   logic          drive_low;
   logic          drive_high;

   assign start_seen = line && (lowrun_q >= RW'(START_LEN));
   assign drive_low  = (state_q == AG_RUN) && (sub_q == 2'd0) && req[slot_q];
   assign drive_high = (state_q == AG_RUN) && (sub_q == 2'd1) && low_q;
   assign drv_en     = drive_low | drive_high;
   assign drv_val    = drive_high;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lowrun_q <= '0;
         low_q    <= 1'b0;
      end else begin
         low_q <= drive_low;
         if (line)                            lowrun_q <= '0;
         else if (lowrun_q != RW'(START_LEN)) lowrun_q <= lowrun_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= AG_IDLE;
         sub_q   <= '0;
         slot_q  <= '0;
      end else begin
         case (state_q)
            AG_IDLE: if (start_seen) state_q <= AG_LEAD;
            AG_LEAD: begin
               state_q <= AG_RUN;
               sub_q   <= '0;
               slot_q  <= '0;
            end
            AG_RUN: begin
               if (sub_q == 2'd2) begin
                  sub_q <= '0;
                  if (slot_q == SW'(NUM_SLOTS - 1)) state_q <= AG_IDLE;
                  else                              slot_q  <= slot_q + 1'b1;
               end else begin
                  sub_q <= sub_q + 1'b1;
               end
            end
            default: state_q <= AG_IDLE;
         endcase
      end
   end

   // R9: the slot driver also returns the line high for one clock
   assert_agent_high_after_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(drv_en && !drv_val) |-> (drv_en && drv_val));

   // R9: after its high clock the slot driver lets go
   assert_agent_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(drv_en && drv_val) |-> !drv_en);

endmodule

// File: rtl/sirq_line_merge.sv
module sirq_line_merge #(
   parameter int unsigned N_DRV = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_DRV-1:0] drv_en,
   input  logic [N_DRV-1:0] drv_val,
   output logic             line
);

   logic [N_DRV-1:0] pull_low;
   logic [N_DRV-1:0] push_high;

   for (genvar d = 0; d < N_DRV; d++) begin : g_drv
      assign pull_low[d]  = drv_en[d] & ~drv_val[d];
      assign push_high[d] = drv_en[d] &  drv_val[d];
   end

   // pull-up wins when nobody pulls low
   assign line = ~|pull_low;

   // R12: no driver pushes high while another pulls low
   assert_no_contention_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !((|pull_low) && (|push_high)));

endmodule

// File: rtl/sirq_frame_host.sv
module sirq_frame_host
   import sirq_pkg::*;
#(
   parameter int unsigned NUM_SLOTS = 17,
   parameter int unsigned START_LEN = 4,
   parameter int unsigned STOP_LEN  = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sirq_in,
   output logic                 sirq_oe,
   output logic                 sirq_out,
   output logic [NUM_SLOTS-1:0] irq_level
);

   localparam int unsigned SW       = $clog2(NUM_SLOTS);
   localparam int unsigned FRAME_CK = frame_clocks(NUM_SLOTS, START_LEN, STOP_LEN);

   initial begin : param_check
      if (NUM_SLOTS < 2)         $fatal(1, "NUM_SLOTS must be at least 2");
      if (STOP_LEN < 1)          $fatal(1, "STOP_LEN must be at least 1");
      if (START_LEN <= STOP_LEN) $fatal(1, "START_LEN must exceed STOP_LEN");
      if (FRAME_CK < 8)          $fatal(1, "frame too short");
   end

   logic          sample_stb;
   logic          frame_end;
   logic [SW-1:0] slot_idx;

   sirq_frame_seq #(
      .NUM_SLOTS (NUM_SLOTS),
      .START_LEN (START_LEN),
      .STOP_LEN  (STOP_LEN)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .drv_en     (sirq_oe),
      .drv_val    (sirq_out),
      .sample_stb (sample_stb),
      .slot_idx   (slot_idx),
      .frame_end  (frame_end)
   );

   sirq_slot_capture #(
      .NUM_SLOTS (NUM_SLOTS)
   ) u_cap (
      .clk        (clk),
      .rst_n      (rst_n),
      .line       (sirq_in),
      .sample_stb (sample_stb),
      .slot_idx   (slot_idx),
      .frame_end  (frame_end),
      .irq_level  (irq_level)
   );

endmodule

// File: tb/tb_sirq_frame_host.sv
module tb_sirq_frame_host;

   localparam int NS = 17;
   localparam int ST = 4;
   localparam int SP = 2;
   localparam int FL = ST + 2 + 3 * NS + SP + 2;   // 61 clocks per frame

   typedef struct packed {
      logic [NS-1:0] req;
      logic [NS-1:0] exp;
   } vec_t;

   // request pattern and the irq_level expected one frame later (R5)
   localparam vec_t VEC [6] = '{
      '{17'h1FFFF, 17'h1FFFF},
      '{17'h00001, 17'h00001},
      '{17'h10000, 17'h10000},
      '{17'h0AAAA, 17'h0AAAA},
      '{17'h15555, 17'h15555},
      '{17'h00F0F, 17'h00F0F}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          host_oe, host_out, ag_oe, ag_out;
   logic          rg_oe = 1'b0;
   logic          line;
   logic [NS-1:0] req = '0;
   logic [NS-1:0] irq;

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   sirq_line_merge #(.N_DRV(3)) u_line (
      .clk     (clk),
      .rst_n   (rst_n),
      .drv_en  ({rg_oe, ag_oe, host_oe}),
      .drv_val ({1'b0, ag_out, host_out}),
      .line    (line)
   );

   sirq_frame_host #(.NUM_SLOTS(NS), .START_LEN(ST), .STOP_LEN(SP)) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .sirq_in   (line),
      .sirq_oe   (host_oe),
      .sirq_out  (host_out),
      .irq_level (irq)
   );

   sirq_slot_agent #(.NUM_SLOTS(NS), .START_LEN(ST)) u_agent (
      .clk     (clk),
      .rst_n   (rst_n),
      .line    (line),
      .req     (req),
      .drv_en  (ag_oe),
      .drv_val (ag_out)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s at frame clock %0d: actual %0h expected %0h", tag, cyc % FL, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #2;
      cyc++;
   endtask

   task automatic goto(input int p);
      step();
      while ((cyc % FL) != p) step();
   endtask

   // {enable, value} the host must show in frame clock p (R1..R4)
   function automatic logic [1:0] host_exp(input int p);
      if (p < ST)                      return 2'b10;
      if (p == ST)                     return 2'b11;
      if (p >= FL - SP - 2 && p < FL - 2) return 2'b10;
      if (p == FL - 2)                 return 2'b11;
      return 2'b00;
   endfunction

   function automatic string host_tag(input int p);
      if (p < ST)            return "R1";
      if (p <= ST + 1)       return "R2";
      if (p < FL - SP - 2)   return "R3";
      return "R4";
   endfunction

   // {enable, value} the slot driver must show in frame clock p (R9, R10)
   function automatic logic [1:0] agent_exp(input int p, input logic [NS-1:0] r);
      int k;
      if (p < ST + 2 || p >= ST + 2 + 3 * NS) return 2'b00;
      k = p - (ST + 2);
      if (!r[k / 3])    return 2'b00;
      if (k % 3 == 0)   return 2'b10;
      if (k % 3 == 1)   return 2'b11;
      return 2'b00;
   endfunction

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         summary();
         $finish;
      end
   end

   initial begin : main
      logic [1:0] he, ae;
      logic [NS-1:0] prev;

      // R7: state while reset is held
      repeat (3) @(posedge clk);
      #2;
      chk("R7 irq in reset", 32'(irq), 32'h0);
      chk("R7 host released in reset", 32'(host_oe), 32'h0);

      rst_n = 1'b1;
      cyc   = 0;
      #1;
      // R1: start pulse begins in the first clock after release
      chk("R1 first clock", {30'h0, host_oe, host_oe ? host_out : 1'b0}, 32'h2);

      // table walk, R5
      for (int i = 0; i < 6; i++) begin
         goto(1);
         req = VEC[i].req;
         goto(1);
         chk("R5 pattern", 32'(irq), 32'(VEC[i].exp));
      end

      // R6: a new pattern stays hidden until the frame closes
      prev = VEC[5].exp;
      goto(1);
      req = 17'h0C3C3;
      goto(30);
      chk("R6 mid frame", 32'(irq), 32'(prev));
      goto(FL - 1);
      chk("R6 last clock", 32'(irq), 32'(prev));
      step();
      chk("R6 next frame", 32'(irq), 32'h0C3C3);

      // full frame walk with every request raised: R1..R4, R9..R12
      goto(1);
      req = '1;
      goto(0);
      for (int p = 0; p < FL; p++) begin
         he = host_exp(p);
         ae = agent_exp(p, req);
         chk(host_tag(p), {30'h0, host_oe, host_oe ? host_out : 1'b0}, 32'(he));
         chk((ae[1] || (p >= ST + 2 && p < ST + 2 + 3 * NS)) ? "R9" : "R10",
             {30'h0, ag_oe, ag_oe ? ag_out : 1'b0}, 32'(ae));
         chk("R11 line", 32'(line), 32'(!(he == 2'b10 || ae == 2'b10)));
         chk("R12 one driver", 32'(host_oe && ag_oe), 32'h0);
         step();
      end
      chk("R4 next start", {30'h0, host_oe, host_oe ? host_out : 1'b0}, 32'h2);

      // R8: lows outside sample clocks are ignored, a sampled low counts
      goto(1);
      req = '0;
      goto(ST + 2 + 3 * 3 + 1);          // recovery of slot 3
      rg_oe = 1'b1;
      #1;
      chk("R11 pulled low", 32'(line), 32'h0);
      step();
      rg_oe = 1'b0;
      goto(ST + 2 + 3 * 5 + 2);          // turnaround of slot 5
      rg_oe = 1'b1;
      step();
      rg_oe = 1'b0;
      goto(ST + 2 + 3 * 9);              // sample of slot 9
      rg_oe = 1'b1;
      step();
      rg_oe = 1'b0;
      goto(1);
      chk("R8 only sampled slot", 32'(irq), 32'(1 << 9));

      // R7: reset in mid-run clears without a clock edge
      goto(20);
      rst_n = 1'b0;
      #1;
      chk("R7 async irq", 32'(irq), 32'h0);
      chk("R7 async release", 32'(host_oe), 32'h0);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule